// File: doc/BRIEF.md
# Start-Aligned Stream Deserializer

This block turns a fast stream of narrow elements, one per clock, into wide vectors of `RATIO` elements. Each group is framed by an optional start strobe and an optional per-sample qualifier. The first element of a group lands in the least significant lane. When the last element of a group is captured, the whole vector is registered onto the wide output and a one-clock valid pulse marks it. After every finished group the block skips a fixed number (`IDLE`) of qualified samples before it collects again.

With start gating enabled, a group opens only when start and the qualifier are high together. A second such coincidence before the group is full throws away the partial group and restarts from that sample. With start gating disabled, any qualified sample opens a group while none is in progress. With qualifier gating disabled, every clock carries a sample. Between vectors the output keeps the last vector it emitted. Until the first vector, the output shows a parameterized initial value.

Top module: `stream_deser`

## Requirements
- R1: Element k of a group (k = 0 first) appears in `out_vec[k*ELEM_W +: ELEM_W]`, so input A then B gives B in the upper lane and A in the lower lane.
- R2: `out_vld` is high for exactly one clock, in the cycle after the edge that captures the last element of a group, and `out_vec` takes the new vector at that same edge.
- R3: With start gating on, a group opens only on a sample with `in_start`=1 and `in_vld`=1. A sample with start high and qualifier low is dropped. A qualified sample with start low while no group is open is also dropped.
- R4: With start gating on, a start-and-qualifier sample during an open group discards the partial group, produces no vector for it, and becomes element 0 of a new group.
- R5: After a group completes, the next `IDLE` qualified samples are ignored, including any start, and collection resumes after them.
- R6: While `out_vld` is low, `out_vec` holds its previous value.
- R7: Synchronous active-high `rst` sets `out_vec` to `INIT_VAL` and `out_vld` to 0, and leaves no group open and no idle samples pending.
- R8: With start gating off (`USE_START`=0), a qualified sample opens a group whenever no group is open.
- R9: With qualifier gating off (`USE_VALID`=0), `in_vld` is ignored and every clock supplies a sample.
- R10: With qualifier gating on, samples with `in_vld`=0 inside an open group are skipped without closing or restarting the group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one input element per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_elem | input | ELEM_W | Input stream element |
| in_vld | input | 1 | Sample qualifier (ignored when `USE_VALID`=0) |
| in_start | input | 1 | Group start strobe (ignored when `USE_START`=0) |
| out_vec | output | RATIO*ELEM_W | Assembled vector, element 0 in the low lane |
| out_vld | output | 1 | One-clock pulse marking a new vector |

## Verification
On every cycle the assertions check several rules. The element counter stays inside the group, and no group is open while idle samples are pending. A pulse on `out_vld` always follows a write of the last lane, and the output holds whenever `out_vld` is low. Lane order, the discard of a partial group on an early start, the dropping of unpaired start and qualifier samples, and the exact count of skipped idle samples show only in the data. The bench's directed sequences and its reference model over random stimulus cover these, on one instance with both gates enabled and one with both disabled.

// File: rtl/stream_deser_pkg.sv
package stream_deser_pkg;

   // Width of a counter that must hold values 0 .. n-1, never below one bit.
   function automatic int cnt_width(input int n);
      int w;
      w = (n <= 1) ? 1 : $clog2(n);
      return w;
   endfunction

endpackage

// File: rtl/sdz_ctrl.sv
module sdz_ctrl #(
   parameter int RATIO     = 4,
   parameter int IDLE      = 1,
   parameter bit USE_START = 1'b1,
   parameter bit USE_VALID = 1'b1,
   localparam int CNT_W    = stream_deser_pkg::cnt_width(RATIO),
   localparam int IDLE_W   = stream_deser_pkg::cnt_width(IDLE + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_vld,
   input  logic             in_start,
   output logic             wr_en,
   output logic [CNT_W-1:0] wr_idx,
   output logic             done
);

   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(RATIO - 1);

   logic              smp_ok;
   logic              open_ok;
   logic              skip_act;
   logic              begin_grp;
   logic              cont_grp;
   logic              busy_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [IDLE_W-1:0] idle_q;

   initial begin
      assert (RATIO >= 1) else $error("sdz_ctrl: RATIO must be at least 1");
      assert (IDLE >= 0)  else $error("sdz_ctrl: IDLE must not be negative");
   end

   // Sample qualifier variant
   generate
      if (USE_VALID) begin : g_vld_gate
         assign smp_ok = in_vld;
      end else begin : g_vld_free
         logic unused_vld;
         assign unused_vld = in_vld;
         assign smp_ok     = 1'b1;
      end
   endgenerate

   // Group-open rule variant
   generate
      if (USE_START) begin : g_start_gate
         assign open_ok = in_start;
      end else begin : g_start_free
         logic unused_start;
         assign unused_start = in_start;
         assign open_ok      = ~busy_q;
      end
   endgenerate

   always_comb begin
      skip_act  = (idle_q != '0);
      begin_grp = ~skip_act & smp_ok & open_ok;
      cont_grp  = ~skip_act & smp_ok & busy_q & ~begin_grp;
      wr_en     = begin_grp | cont_grp;
      wr_idx    = begin_grp ? '0 : cnt_q;
      done      = wr_en & (wr_idx == LAST_IDX);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (done) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (wr_en) begin
         cnt_q  <= wr_idx + CNT_W'(1);
         busy_q <= 1'b1;
      end
   end

   // Idle skipper variant
   generate
      if (IDLE > 0) begin : g_idle_cnt
         always_ff @(posedge clk) begin
            if (rst) begin
               idle_q <= '0;
            end else if (done) begin
               idle_q <= IDLE_W'(IDLE);
            end else if (skip_act && smp_ok) begin
               idle_q <= idle_q - IDLE_W'(1);
            end
         end

         AST_IDLE_LOADED: assert property (@(posedge clk) disable iff (rst)
            done |=> (idle_q == IDLE_W'(IDLE)))
            else $error("idle count not loaded after group"); // R5
      end else begin : g_idle_none
         assign idle_q = '0;
      end
   endgenerate

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LAST_IDX)
      else $error("element counter beyond group"); // R1

   AST_IDLE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
      (idle_q != '0) |-> !busy_q)
      else $error("group open while skipping idle samples"); // R5

   AST_CNT_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
      !busy_q |-> (cnt_q == '0))
      else $error("stale count with no open group"); // R4

   AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (rst)
      done |=> !busy_q)
      else $error("group still open after completion"); // R2

endmodule

// File: rtl/sdz_gather.sv
module sdz_gather #(
   parameter int ELEM_W  = 8,
   parameter int RATIO   = 4,
   localparam int CNT_W  = stream_deser_pkg::cnt_width(RATIO),
   localparam int VEC_W  = RATIO * ELEM_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [CNT_W-1:0]  wr_idx,
   input  logic [ELEM_W-1:0] din,
   output logic [VEC_W-1:0]  full_vec
);

   initial begin
      assert (ELEM_W >= 1) else $error("sdz_gather: ELEM_W must be at least 1");
   end

   generate
      if (RATIO > 1) begin : g_lanes
         // Lanes 0..RATIO-2 are stored; the top lane is taken straight from din
         for (genvar i = 0; i < RATIO - 1; i++) begin : g_lane
            logic [ELEM_W-1:0] lane_q;
            always_ff @(posedge clk) begin
               if (rst) begin
                  lane_q <= '0;
               end else if (wr_en && (wr_idx == CNT_W'(i))) begin
                  lane_q <= din;
               end
            end
            assign full_vec[i*ELEM_W +: ELEM_W] = lane_q;
         end
         assign full_vec[(RATIO-1)*ELEM_W +: ELEM_W] = din;
      end else begin : g_single
         logic unused_ctl;
         assign unused_ctl = clk ^ rst ^ wr_en ^ (^wr_idx);
         assign full_vec   = din;
      end
   endgenerate

endmodule

// File: rtl/sdz_outreg.sv
module sdz_outreg #(
   parameter int              WIDTH    = 32,
   parameter logic [WIDTH-1:0] INIT_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q,
   output logic             q_vld
);

   always_ff @(posedge clk) begin
      if (rst) begin
         q     <= INIT_VAL;
         q_vld <= 1'b0;
      end else begin
         q_vld <= load;
         if (load) begin
            q <= din;
         end
      end
   end

   AST_HOLD_NO_VLD: assert property (@(posedge clk) disable iff (rst)
      !q_vld |-> $stable(q))
      else $error("output vector moved without valid"); // R6

endmodule

// File: rtl/stream_deser.sv
module stream_deser #(
   parameter int ELEM_W    = 8,
   parameter int RATIO     = 4,
   parameter int IDLE      = 1,
   parameter bit USE_START = 1'b1,
   parameter bit USE_VALID = 1'b1,
   parameter logic [RATIO*ELEM_W-1:0] INIT_VAL = '0
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [ELEM_W-1:0]       in_elem,
   input  logic                    in_vld,
   input  logic                    in_start,
   output logic [RATIO*ELEM_W-1:0] out_vec,
   output logic                    out_vld
);

   localparam int VEC_W = RATIO * ELEM_W;
   localparam int CNT_W = stream_deser_pkg::cnt_width(RATIO);

   logic             wr_en;
   logic [CNT_W-1:0] wr_idx;
   logic             done;
   logic [VEC_W-1:0] full_vec;

   sdz_ctrl #(
      .RATIO     (RATIO),
      .IDLE      (IDLE),
      .USE_START (USE_START),
      .USE_VALID (USE_VALID)
   ) ctrl_i (
      .clk      (clk),
      .rst      (rst),
      .in_vld   (in_vld),
      .in_start (in_start),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .done     (done)
   );

   sdz_gather #(
      .ELEM_W (ELEM_W),
      .RATIO  (RATIO)
   ) gather_i (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .din      (in_elem),
      .full_vec (full_vec)
   );

   sdz_outreg #(
      .WIDTH    (VEC_W),
      .INIT_VAL (INIT_VAL)
   ) outreg_i (
      .clk   (clk),
      .rst   (rst),
      .load  (done),
      .din   (full_vec),
      .q     (out_vec),
      .q_vld (out_vld)
   );

   AST_VLD_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> $past(wr_en))
      else $error("valid pulse without a captured element"); // R2

   AST_VLD_LAST_LANE: assert property (@(posedge clk) disable iff (rst)
      out_vld |-> ($past(wr_idx) == CNT_W'(RATIO - 1)))
      else $error("valid pulse before group was full"); // R2

endmodule

// File: tb/stream_deser_tb_top.sv
`timescale 1ns/1ps
module stream_deser_tb_top;

   localparam logic [31:0] INIT1 = 32'h0BAD_F00D;
   localparam logic [15:0] INIT2 = 16'h1234;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  in_elem = '0;
   logic        in_vld = 1'b0;
   logic        in_start = 1'b0;
   logic [31:0] vec1;
   logic        vld1;
   logic [15:0] vec2;
   logic        vld2;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   // Both gates on: RATIO 4, IDLE 1
   stream_deser #(.ELEM_W(8), .RATIO(4), .IDLE(1), .USE_START(1'b1),
                  .USE_VALID(1'b1), .INIT_VAL(INIT1)) dut_i (
      .clk(clk), .rst(rst), .in_elem(in_elem), .in_vld(in_vld),
      .in_start(in_start), .out_vec(vec1), .out_vld(vld1));

   // Both gates off: RATIO 2, IDLE 1
   stream_deser #(.ELEM_W(8), .RATIO(2), .IDLE(1), .USE_START(1'b0),
                  .USE_VALID(1'b0), .INIT_VAL(INIT2)) dut2_i (
      .clk(clk), .rst(rst), .in_elem(in_elem), .in_vld(in_vld),
      .in_start(in_start), .out_vec(vec2), .out_vld(vld2));

   // Reference state
   int          m1_cnt, m1_idle, m2_cnt, m2_idle;
   logic [7:0]  m1_buf [4];
   logic [7:0]  m2_buf [2];
   logic [31:0] e1_vec;
   logic        e1_vld;
   logic [15:0] e2_vec;
   logic        e2_vld;

   function automatic logic [31:0] pack4(input logic [7:0] a, b, c, d);
      return {d, c, b, a};
   endfunction

   task automatic model_reset();
      m1_cnt = 0; m1_idle = 0; m2_cnt = 0; m2_idle = 0;
      e1_vec = INIT1; e1_vld = 1'b0;
      e2_vec = INIT2; e2_vld = 1'b0;
   endtask

   task automatic model1(input logic [7:0] e, input bit v, input bit s);
      bit take;
      e1_vld = 1'b0;
      take   = 1'b0;
      if (v) begin
         if (m1_idle > 0) begin
            m1_idle--;
         end else if (s) begin
            m1_buf[0] = e; m1_cnt = 1; take = 1'b1;
         end else if (m1_cnt > 0) begin
            m1_buf[m1_cnt] = e; m1_cnt++; take = 1'b1;
         end
      end
      if (take && m1_cnt == 4) begin
         e1_vec  = pack4(m1_buf[0], m1_buf[1], m1_buf[2], m1_buf[3]);
         e1_vld  = 1'b1;
         m1_cnt  = 0;
         m1_idle = 1;
      end
   endtask

   task automatic model2(input logic [7:0] e);
      e2_vld = 1'b0;
      if (m2_idle > 0) begin
         m2_idle--;
      end else begin
         m2_buf[m2_cnt] = e;
         m2_cnt++;
         if (m2_cnt == 2) begin
            e2_vec  = {m2_buf[1], m2_buf[0]};
            e2_vld  = 1'b1;
            m2_cnt  = 0;
            m2_idle = 1;
         end
      end
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Called at a falling edge: drive, step models, then compare at next falling edge
   task automatic cycle(input logic [7:0] e, input bit v, input bit s,
                        input string t1, input string t2);
      in_elem = e; in_vld = v; in_start = s;
      model1(e, v, s);
      model2(e);
      @(negedge clk);
      chk({t1, " out_vld"}, {31'b0, vld1}, {31'b0, e1_vld});
      chk({t1, " out_vec"}, vec1, e1_vec);
      chk({t2, " dut2 out_vld"}, {31'b0, vld2}, {31'b0, e2_vld});
      chk({t2, " dut2 out_vec"}, {16'b0, vec2}, {16'b0, e2_vec});
   endtask

   task automatic do_reset();
      rst = 1'b1; in_vld = 1'b0; in_start = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      model_reset();
      chk("R7 reset out_vec", vec1, INIT1);
      chk("R7 reset out_vld", {31'b0, vld1}, 32'd0);
      chk("R7 reset dut2 out_vec", {16'b0, vec2}, {16'b0, INIT2});
      chk("R7 reset dut2 out_vld", {31'b0, vld2}, 32'd0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      model_reset();
      do_reset();

      // R1 R2: basic group, lane order and pulse timing
      cycle(8'h11, 1, 1, "R2 first elem", "R9");
      cycle(8'h22, 1, 0, "R2 mid", "R9");
      cycle(8'h33, 1, 0, "R2 mid", "R9");
      chk("R2 no early valid", {31'b0, vld1}, 32'd0);
      cycle(8'h44, 1, 0, "R2 last elem", "R9");
      chk("R1 lane order", vec1, 32'h4433_2211);
      chk("R2 valid pulse", {31'b0, vld1}, 32'd1);
      // R5: the next qualified sample is skipped even with start
      cycle(8'h99, 1, 1, "R5 idle sample", "R9");
      chk("R2 pulse ends", {31'b0, vld1}, 32'd0);
      chk("R6 hold after pulse", vec1, 32'h4433_2211);
      // R3: unpaired start and unpaired valid are dropped
      cycle(8'h55, 0, 1, "R3 start no valid", "R9");
      cycle(8'h66, 1, 0, "R3 valid no start", "R9");
      cycle(8'hA0, 1, 1, "R3 open", "R9");
      cycle(8'hA1, 1, 0, "R3", "R9");
      cycle(8'hA2, 1, 0, "R3", "R9");
      cycle(8'hA3, 1, 0, "R3 close", "R9");
      chk("R3 dropped samples absent", vec1, 32'hA3A2_A1A0);
      // R4: early start discards partial group (idle sample first)
      cycle(8'h00, 1, 0, "R5 idle", "R9");
      cycle(8'hB0, 1, 1, "R4 open", "R9");
      cycle(8'hB1, 1, 0, "R4 partial", "R9");
      cycle(8'hC0, 1, 1, "R4 restart", "R9");
      cycle(8'hC1, 1, 0, "R4", "R9");
      chk("R4 no vector for partial", {31'b0, vld1}, 32'd0);
      // R10: gaps inside a group
      cycle(8'hEE, 0, 0, "R10 gap", "R9");
      cycle(8'hC2, 1, 0, "R10", "R9");
      cycle(8'hEF, 0, 1, "R10 gap with start", "R9");
      cycle(8'hC3, 1, 0, "R10 close", "R9");
      chk("R4 R10 restarted vector", vec1, 32'hC3C2_C1C0);

      // R8 R9: dut2 from clean state, qualifier low on some samples
      do_reset();
      cycle(8'hA1, 0, 0, "R6", "R8 open without start");
      cycle(8'hB2, 1, 0, "R6", "R9 second");
      chk("R9 first pair", {16'b0, vec2}, 32'h0000_B2A1);
      chk("R8 pulse", {31'b0, vld2}, 32'd1);
      cycle(8'hB2, 0, 0, "R6", "R5 idle skip");
      cycle(8'hC3, 0, 0, "R6", "R9 valid low counted");
      cycle(8'hD4, 1, 0, "R6", "R9");
      chk("R5 idle dropped dut2", {16'b0, vec2}, 32'h0000_D4C3);
      chk("R6 dut_i untouched", vec1, INIT1);

      // Random phase
      for (int n = 0; n < 3000; n++) begin
         logic [7:0] e;
         bit v, s;
         e = 8'($urandom);
         v = ($urandom % 10) < 7;
         s = ($urandom % 100) < 15;
         cycle(e, v, s, "R1 R2 R6 random", "R8 R9 random");
         if (n == 1500) do_reset();
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : seed
      int unused_seed;
      unused_seed = $urandom(32'd20240);
   end

endmodule